// File: doc/BRIEF.md
# PWM Emergency Shutdown Controller

This block sits between a bank of PWM channel generators and the output pins. It watches an asynchronous emergency input. While shutdown is enabled and that input is at its active level, every enabled channel is driven to a programmable safe level straight away, whatever the PWM waveform is doing. The forcing is latched in each channel. Once a channel is forced, it returns to its normal waveform only through a release sequence that stays in step with that channel's own period.

Software controls the block through one 8-bit control register. Every change of the emergency input, in either direction, sets a sticky event flag. Software clears the flag by writing 1 to it, and the flag can raise an interrupt when the interrupt enable is set. To recover, software writes a restart trigger while the input is inactive. Each held channel is then released at the next counter-zero strobe that its generator reports. The PWM generators, their counters and any clock prescaling are outside this block.

Control register layout: bit0 shutdown enable, bit1 input polarity (1 = high is active, 0 = low is active), bit2 synchronized input level (read-only), bit3 restart trigger (write-only, reads 0), bit4 override level, bit5 interrupt enable, bit6 event flag (write 1 to clear), bit7 reads 0.

Top module: `pwm_estop_ctrl`

## Requirements
- R1: With shutdown enable at 1, the second rising clock edge after the emergency input reaches its active level forces every channel with chan_en=1 to the override level, without waiting for a counter-zero strobe. While forced, such a channel ignores pwm_in. Channels with chan_en=0 always pass pwm_in.
- R2: Override level bit4 = 0 forces the outputs to 0, and bit4 = 1 forces them to 1.
- R3: Polarity bit1 = 1 treats a high input as active, and bit1 = 0 treats a low input as active.
- R4: Any change of the synchronized emergency input, in either direction, sets event flag bit6 on the third rising edge after the input pin changes.
- R5: Writing 1 to bit6 clears the flag, and writing 0 to bit6 leaves it unchanged.
- R6: irq is 1 exactly when the flag is 1 and interrupt enable bit5 is 1.
- R7: A write with bit3=1 while the synchronized input is inactive is accepted. After it, each held channel is released on the first rising edge after the write at which its cnt_zero is 1. A cnt_zero on the same edge as the write does not release the channel, and channels are released independently.
- R8: A write with bit3=1 while the synchronized input is active is discarded. Later counter-zero strobes do not release the channels.
- R9: Bit3 always reads 0, bit7 reads 0, and bit2 reads the synchronized input level two edges after the pin changes.
- R10: If shutdown enable is cleared while channels are held, they stay forced until their own next cnt_zero, even without a restart trigger.
- R11: After reset all control bits and the flag are 0, irq is 0, and no channel is forced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register read value |
| estop_raw | input | 1 | Asynchronous emergency input |
| chan_en | input | NCH | Per-channel enable |
| pwm_in | input | NCH | Waveforms from the PWM generators |
| cnt_zero | input | NCH | Per-channel counter-zero strobes |
| pwm_out | output | NCH | Channel outputs after override |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps both polarities, both override levels and two enable patterns. In each case it times the forcing edge exactly, so a design that forced one cycle early or waited for a period boundary fails. It issues a restart while the input is still active and then supplies counter-zero strobes, which catches a design that holds the trigger pending. It places a counter-zero strobe on the same edge as an accepted restart and then releases one channel alone, which exposes early release or release that is not per channel. It also clears the shutdown enable during a hold to confirm that the channels wait for counter zero, and it writes 0 to the flag to confirm that the flag is sticky.

// File: rtl/pwm_estop_pkg.sv
package pwm_estop_pkg;

    localparam int REG_W  = 8;
    localparam int B_SDEN = 0;
    localparam int B_POL  = 1;
    localparam int B_STAT = 2;
    localparam int B_RST  = 3;
    localparam int B_LVL  = 4;
    localparam int B_IE   = 5;
    localparam int B_FLAG = 6;

    typedef struct packed {
        logic ie;
        logic lvl;
        logic pol;
        logic sd_en;
    } ctrl_t;

    function automatic logic level_active(input logic lvl_in, input logic pol);
        return ~(lvl_in ^ pol);
    endfunction

    function automatic logic [REG_W-1:0] pack_rd(input ctrl_t c, input logic flag,
                                                 input logic stat);
        logic [REG_W-1:0] r;
        r         = '0;
        r[B_SDEN] = c.sd_en;
        r[B_POL]  = c.pol;
        r[B_STAT] = stat;
        r[B_LVL]  = c.lvl;
        r[B_IE]   = c.ie;
        r[B_FLAG] = flag;
        return r;
    endfunction

endpackage

// File: rtl/estop_sync.sv
module estop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic lvl_s,
    output logic toggle
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], raw};
    end

    assign lvl_s  = sh[STAGES-1];
    assign toggle = sh[STAGES] ^ sh[STAGES-1];
endmodule

// File: rtl/estop_regs.sv
module estop_regs
    import pwm_estop_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             toggle,
    input  logic             active,
    output ctrl_t            ctrl,
    output logic             flag,
    output logic             restart_acc,
    output logic             irq
);
    logic unused_bits;
    assign unused_bits = ^{wr_data[B_STAT], wr_data[REG_W-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            flag <= 1'b0;
        end else begin
            if (wr_en) begin
                ctrl.sd_en <= wr_data[B_SDEN];
                ctrl.pol   <= wr_data[B_POL];
                ctrl.lvl   <= wr_data[B_LVL];
                ctrl.ie    <= wr_data[B_IE];
            end
            if (toggle)                     flag <= 1'b1;
            else if (wr_en && wr_data[B_FLAG]) flag <= 1'b0;
        end
    end

    assign restart_acc = wr_en & wr_data[B_RST] & ~active;
    assign irq         = flag & ctrl.ie;

    a_r4_toggle_sets: assert property (@(posedge clk) disable iff (rst)
        toggle |=> flag);
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !(wr_en && wr_data[B_FLAG])) |=> flag);
    a_r5_w1c: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[B_FLAG] && !toggle) |=> !flag);
endmodule

// File: rtl/estop_chan.sv
module estop_chan (
    input  logic clk,
    input  logic rst,
    input  logic force_now,
    input  logic restart_acc,
    input  logic sd_en,
    input  logic lvl,
    input  logic chan_en,
    input  logic pwm_in,
    input  logic cnt_zero,
    output logic pwm_out
);
    logic hold, pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= 1'b0;
            pend <= 1'b0;
        end else if (force_now) begin
            hold <= 1'b1;
            pend <= 1'b0;
        end else if (hold && cnt_zero && (pend || !sd_en)) begin
            hold <= 1'b0;
            pend <= 1'b0;
        end else if (hold && restart_acc) begin
            pend <= 1'b1;
        end
    end

    assign pwm_out = (chan_en && (force_now || hold)) ? lvl : pwm_in;

    a_r1_trip_latches: assert property (@(posedge clk) disable iff (rst)
        force_now |=> hold);
    a_r7_wait_zero: assert property (@(posedge clk) disable iff (rst)
        (hold && !cnt_zero) |=> hold);
    a_r8_pend_needs_trigger: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(restart_acc));
endmodule

// File: rtl/pwm_estop_ctrl.sv
module pwm_estop_ctrl
    import pwm_estop_pkg::*;
#(
    parameter int NCH         = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             estop_raw,
    input  logic [NCH-1:0]   chan_en,
    input  logic [NCH-1:0]   pwm_in,
    input  logic [NCH-1:0]   cnt_zero,
    output logic [NCH-1:0]   pwm_out,
    output logic             irq
);
    ctrl_t ctrl;
    logic  lvl_s, toggle, active, flag, restart_acc, force_now;

    estop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .raw(estop_raw), .lvl_s(lvl_s), .toggle(toggle)
    );

    assign active    = level_active(lvl_s, ctrl.pol);
    assign force_now = ctrl.sd_en & active;

    estop_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .toggle(toggle), .active(active), .ctrl(ctrl), .flag(flag),
        .restart_acc(restart_acc), .irq(irq)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        estop_chan u_ch (
            .clk(clk), .rst(rst), .force_now(force_now),
            .restart_acc(restart_acc), .sd_en(ctrl.sd_en), .lvl(ctrl.lvl),
            .chan_en(chan_en[i]), .pwm_in(pwm_in[i]), .cnt_zero(cnt_zero[i]),
            .pwm_out(pwm_out[i])
        );
    end

    assign rd_data = pack_rd(ctrl, flag, lvl_s);

    a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> (rd_data[B_FLAG] && rd_data[B_IE]));
    a_r9_restart_reads_zero: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en) |-> !rd_data[B_RST]);
endmodule

// File: tb/tb_pwm_estop_ctrl.sv
module tb_pwm_estop_ctrl;
    localparam int N = 6;
    localparam logic [7:0] SDEN = 8'h01, RSTB = 8'h08, FLAG = 8'h40;

    logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, estop_raw = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [N-1:0] chan_en = '0, pwm_in = '0, cnt_zero = '0, pwm_out;
    logic irq;
    int nvec = 0, nerr = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwm_estop_ctrl #(.NCH(N)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .estop_raw(estop_raw), .chan_en(chan_en), .pwm_in(pwm_in),
        .cnt_zero(cnt_zero), .pwm_out(pwm_out), .irq(irq)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] expo(input logic [N-1:0] held, input logic [N-1:0] en,
                                          input logic [N-1:0] pin, input logic l);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = (held[i] & en[i]) ? l : pin[i];
        return r;
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            nvec++; nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        logic [7:0] cfg;
        logic p, l;
        pwm_in = 6'b100110; chan_en = '1;
        repeat (3) step();
        rst = 1'b0;
        chk("R11 reset reg", rd_data, 8'h00);
        chk("R11 reset irq", irq, 0);
        chk("R11 reset out", pwm_out, pwm_in);

        for (int k = 0; k < 8; k++) begin
            p = k[0]; l = k[1];
            chan_en = k[2] ? 6'b110101 : 6'b111111;
            pwm_in  = 6'b011010 ^ {p, l, k[2], p, l, k[2]};
            cfg = {2'b00, 1'b1, l, 2'b00, p, 1'b1};
            wr(cfg & ~SDEN);
            estop_raw = ~p;
            repeat (3) step();
            wr(cfg | FLAG);
            chk("R1 idle out", pwm_out, pwm_in);
            chk("R6 idle irq", irq, 0);
            estop_raw = p;
            step();
            chk("R1 still syncing", pwm_out, pwm_in);
            step();
            chk("R1 R2 R3 forced", pwm_out, expo('1, chan_en, pwm_in, l));
            pwm_in = ~pwm_in;
            #1;
            chk("R1 pwm_in ignored", pwm_out, expo('1, chan_en, pwm_in, l));
            step();
            chk("R4 flag on assert", rd_data[6], 1);
            chk("R6 irq", irq, 1);
            chk("R9 status level", rd_data[2], p);
            wr(cfg | RSTB);
            estop_raw = ~p;
            repeat (3) step();
            cnt_zero = '1; step(); cnt_zero = '0;
            chk("R8 discarded restart", pwm_out, expo('1, chan_en, pwm_in, l));
            wr(cfg);
            chk("R5 write 0 keeps flag", rd_data[6], 1);
            wr(cfg | FLAG);
            chk("R5 w1c", rd_data[6], 0);
            chk("R6 irq cleared", irq, 0);
            wr_en = 1'b1; wr_data = cfg | RSTB; cnt_zero = '1;
            step();
            wr_en = 1'b0; wr_data = '0; cnt_zero = '0;
            chk("R7 same-edge zero", pwm_out, expo('1, chan_en, pwm_in, l));
            chk("R9 restart reads 0", rd_data[3], 0);
            cnt_zero = 6'b000001; step(); cnt_zero = '0;
            chk("R7 ch0 only", pwm_out, expo(6'b111110, chan_en, pwm_in, l));
            cnt_zero = '1; step(); cnt_zero = '0;
            chk("R7 all released", pwm_out, pwm_in);
        end

        cfg = 8'h13; chan_en = '1; pwm_in = 6'b010101;
        wr(cfg & ~SDEN);
        estop_raw = 1'b0;
        repeat (3) step();
        wr(cfg | FLAG);
        estop_raw = 1'b1;
        repeat (3) step();
        chk("R10 forced", pwm_out, 6'b111111);
        chk("R6 ie off", irq, 0);
        chk("R4 flag", rd_data[6], 1);
        estop_raw = 1'b0;
        repeat (3) step();
        wr(cfg & ~SDEN);
        chk("R10 hold after disable", pwm_out, 6'b111111);
        cnt_zero = 6'b000100; step(); cnt_zero = '0;
        chk("R10 ch2 released", pwm_out, expo(6'b111011, chan_en, pwm_in, 1'b1));
        cnt_zero = '1; step(); cnt_zero = '0;
        chk("R10 all released", pwm_out, pwm_in);
        chk("R9 bit7 zero", rd_data[7], 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule